// File: doc/BRIEF.md
# Age-Counter LRU Replacement Tracker

This block keeps replacement state for a k-way set-associative cache with a configurable number of sets. Every way of every set carries a valid bit and a small age counter. Age 0 marks the most recently used way, and among the valid ways of a set the ages always form a permutation of 0 up to one less than the number of valid ways. A cache controller presents a set index each cycle. The block answers at once, without a clock edge, with the way to replace in that set and a flag that says whether every way of the set is occupied.

The controller reports activity on the same set index. An access strobe with a hit flag and a hit way refreshes that way's recency. A fill strobe records that a line was placed in the way the block proposed. On a hit, only ways that were younger than the hit way grow older, so the relative order of the remaining ways is kept. A fill makes the new line the youngest and ages every other resident line. Tags, data storage and the memory side belong to the surrounding cache.

Top module: `lru_age_tracker`

## Requirements
- R1: After reset every way of every set is invalid. For any set index, `set_full` reads 0 and `victim_way` reads 0.
- R2: While the addressed set has at least one invalid way, `victim_way` is the lowest-numbered invalid way of that set.
- R3: While all ways of the addressed set are valid, `victim_way` is the way whose age equals WAYS-1, which is the least recently used way.
- R4: A hit (`acc_valid`=1, `acc_hit`=1) on a valid way sets that way's age to 0. It adds one to the age of each valid way whose age was below the hit way's old age, and leaves all other ages unchanged.
- R5: A fill into a set that is not full marks the proposed way valid with age 0 and adds one to the age of every way that was already valid.
- R6: A fill into a full set gives the replaced way age 0 and adds one to the age of every other way. The set stays full.
- R7: An update changes only the set selected by `set_idx` in that cycle. Every other set keeps its state.
- R8: `set_full` is 1 exactly when all WAYS ways of the addressed set are valid.
- R9: When `acc_valid` is 0, `acc_hit` and `hit_way` have no effect on any state.
- R10: If a hit and a fill are presented in the same cycle, only the hit is applied and the fill is dropped.
- R11: A hit that names a way which is not valid in the addressed set leaves the state of that set unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| set_idx | input | clog2(SETS) | Set addressed by outputs and updates |
| acc_valid | input | 1 | Access strobe that qualifies the hit fields |
| acc_hit | input | 1 | The access hit in the cache |
| hit_way | input | clog2(WAYS) | Way that hit |
| fill | input | 1 | A line is placed in the proposed victim way |
| victim_way | output | clog2(WAYS) | Way to replace in the addressed set |
| set_full | output | 1 | All ways of the addressed set are valid |

## Verification
A hit and a fill can arrive in the same cycle on the same set, and only the hit may be applied. The bench provokes this with directed cycles, in both a partly filled set and a full set, that raise `fill` together with a hit on a valid way. The random phase also produces such collisions. The result is judged through the victim and full flags of the following cycles. The reference model applies only the hit, so a design that also performed the fill would show an extra valid way or a different least recently used way.

// File: rtl/lru_age_pkg.sv
package lru_age_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_HIT  = 2'd1,
    OP_FILL = 2'd2
  } lru_op_e;
endpackage

// File: rtl/lru_set_entry.sv
module lru_set_entry
  import lru_age_pkg::*;
#(
  parameter int WAYS = 4,
  parameter int AW   = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sel,
  input  lru_op_e                  op,
  input  logic [AW-1:0]            hit_way,
  input  logic [AW-1:0]            fill_way,
  output logic [WAYS-1:0][AW-1:0]  ages_o,
  output logic [WAYS-1:0]          valid_o
);
  typedef logic [WAYS-1:0][AW-1:0] age_vec_t;

  age_vec_t        ages_q, ages_d;
  logic [WAYS-1:0] valid_q, valid_d;
  logic            hit_apply;
  logic            fill_apply;

  // Hit: the hit way becomes youngest; valid ways younger than its old age grow one step older.
  function automatic age_vec_t age_after_hit(age_vec_t a, logic [WAYS-1:0] v,
                                             logic [AW-1:0] hw);
    age_vec_t      r;
    logic [AW-1:0] pivot;
    pivot = a[hw];
    r = a;
    for (int w = 0; w < WAYS; w++) begin
      if (hw == AW'(w)) r[w] = '0;
      else if (v[w] && (a[w] < pivot)) r[w] = a[w] + AW'(1);
    end
    return r;
  endfunction

  // Fill: the new way becomes youngest; every other resident way ages one step.
  function automatic age_vec_t age_after_fill(age_vec_t a, logic [WAYS-1:0] v,
                                              logic [AW-1:0] fw);
    age_vec_t r;
    r = a;
    for (int w = 0; w < WAYS; w++) begin
      if (fw == AW'(w)) r[w] = '0;
      else if (v[w]) r[w] = a[w] + AW'(1);
    end
    return r;
  endfunction

  assign hit_apply  = sel && (op == OP_HIT) && valid_q[hit_way];
  assign fill_apply = sel && (op == OP_FILL);

  always_comb begin
    ages_d  = ages_q;
    valid_d = valid_q;
    if (hit_apply) begin
      ages_d = age_after_hit(ages_q, valid_q, hit_way);
    end else if (fill_apply) begin
      ages_d           = age_after_fill(ages_q, valid_q, fill_way);
      valid_d[fill_way] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ages_q  <= '0;
      valid_q <= '0;
    end else begin
      ages_q  <= ages_d;
      valid_q <= valid_d;
    end
  end

  assign ages_o  = ages_q;
  assign valid_o = valid_q;

  // R4
  hit_youngest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && op == OP_HIT && valid_q[hit_way]) |=> (ages_q[$past(hit_way)] == '0));

  // R5
  fill_youngest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && op == OP_FILL) |=> (valid_q[$past(fill_way)] && ages_q[$past(fill_way)] == '0));

  // R7
  unselected_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> ($stable(ages_q) && $stable(valid_q)));

  // R11
  stray_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && op == OP_HIT && !valid_q[hit_way]) |=> ($stable(ages_q) && $stable(valid_q)));

  // R6
  full_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && (&valid_q)) |=> (&valid_q));
endmodule

// File: rtl/lru_victim_pick.sv
module lru_victim_pick #(
  parameter int WAYS = 4,
  parameter int AW   = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [WAYS-1:0][AW-1:0]  ages_i,
  input  logic [WAYS-1:0]          valid_i,
  output logic [AW-1:0]            victim_o,
  output logic                     full_o
);
  logic [WAYS-1:0] oldest_mask;
  logic [AW-1:0]   oldest_way;
  logic [AW-1:0]   free_way;

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      oldest_mask[w] = valid_i[w] && (ages_i[w] == AW'(WAYS - 1));
    end
  end

  always_comb begin
    oldest_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (oldest_mask[w]) oldest_way = AW'(w);
    end
  end

  always_comb begin
    free_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!valid_i[w]) free_way = AW'(w);
    end
  end

  assign full_o   = &valid_i;
  assign victim_o = full_o ? oldest_way : free_way;

  // R3
  single_oldest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full_o |-> ($countones(oldest_mask) == 1));

  // R2
  free_victim_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !full_o |-> !valid_i[victim_o]);
endmodule

// File: rtl/lru_age_tracker.sv
module lru_age_tracker
  import lru_age_pkg::*;
#(
  parameter int  WAYS = 4,
  parameter int  SETS = 16,
  localparam int AW   = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int SIW  = (SETS > 1) ? $clog2(SETS) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [SIW-1:0] set_idx,
  input  logic           acc_valid,
  input  logic           acc_hit,
  input  logic [AW-1:0]  hit_way,
  input  logic           fill,
  output logic [AW-1:0]  victim_way,
  output logic           set_full
);
  logic [WAYS-1:0][AW-1:0] set_ages  [SETS];
  logic [WAYS-1:0]         set_valid [SETS];
  logic [WAYS-1:0][AW-1:0] cur_ages;
  logic [WAYS-1:0]         cur_valid;
  logic                    hit_event;
  logic                    fill_event;
  lru_op_e                 op;

  assign hit_event  = acc_valid && acc_hit;
  assign fill_event = fill && !hit_event;
  assign op = hit_event ? OP_HIT : (fill_event ? OP_FILL : OP_IDLE);

  for (genvar s = 0; s < SETS; s++) begin : g_set
    lru_set_entry #(.WAYS(WAYS), .AW(AW)) u_entry (
      .clk      (clk),
      .rst_n    (rst_n),
      .sel      (set_idx == SIW'(s)),
      .op       (op),
      .hit_way  (hit_way),
      .fill_way (victim_way),
      .ages_o   (set_ages[s]),
      .valid_o  (set_valid[s])
    );
  end

  assign cur_ages  = set_ages[set_idx];
  assign cur_valid = set_valid[set_idx];

  lru_victim_pick #(.WAYS(WAYS), .AW(AW)) u_pick (
    .clk      (clk),
    .rst_n    (rst_n),
    .ages_i   (cur_ages),
    .valid_i  (cur_valid),
    .victim_o (victim_way),
    .full_o   (set_full)
  );

  // R10
  hit_over_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_event && fill) |-> (op != OP_FILL));

  // R9
  no_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_valid && !fill) |-> (op == OP_IDLE));
endmodule

// File: tb/lru_age_tracker_test.sv
module lru_age_tracker_test;
  localparam int WAYS = 4;
  localparam int SETS = 16;
  localparam int AW   = 2;
  localparam int SIW  = 4;

  logic           clk = 1'b0;
  logic           rst_n;
  logic [SIW-1:0] set_idx;
  logic           acc_valid;
  logic           acc_hit;
  logic [AW-1:0]  hit_way;
  logic           fill;
  logic [AW-1:0]  victim_way;
  logic           set_full;

  int tests_run = 0;
  int tests_failed = 0;

  // Reference: per set an MRU-first list of resident ways.
  int ord [SETS][WAYS];
  int cnt [SETS];
  bit vld [SETS][WAYS];

  always #5 clk = ~clk;

  lru_age_tracker #(.WAYS(WAYS), .SETS(SETS)) uut (
    .clk(clk), .rst_n(rst_n), .set_idx(set_idx), .acc_valid(acc_valid),
    .acc_hit(acc_hit), .hit_way(hit_way), .fill(fill),
    .victim_way(victim_way), .set_full(set_full)
  );

  function automatic int exp_victim(int s);
    if (cnt[s] < WAYS) begin
      for (int w = 0; w < WAYS; w++) if (!vld[s][w]) return w;
    end
    return ord[s][WAYS-1];
  endfunction

  function automatic void model_to_front(int s, int way);
    int pos;
    pos = cnt[s];
    for (int i = 0; i < cnt[s]; i++) if (ord[s][i] == way) pos = i;
    if (pos == cnt[s]) begin
      cnt[s] = cnt[s] + 1;
    end
    for (int i = pos; i > 0; i--) ord[s][i] = ord[s][i-1];
    ord[s][0] = way;
  endfunction

  function automatic void model_apply(int s, bit av, bit ah, int hw, bit fl);
    int v;
    if (av && ah) begin
      if (vld[s][hw]) model_to_front(s, hw);
    end else if (fl) begin
      v = exp_victim(s);
      if (cnt[s] == WAYS) begin
        cnt[s] = WAYS - 1;
      end
      model_to_front(s, v);
      vld[s][v] = 1'b1;
    end
  endfunction

  task automatic check_outputs(int s, string tag);
    int ev;
    bit ef;
    ev = exp_victim(s);
    ef = (cnt[s] == WAYS);
    tests_run++;
    if (victim_way !== AW'(ev) || set_full !== ef) begin
      tests_failed++;
      $display("FAIL %s set %0d: victim=%0d full=%0b expected victim=%0d full=%0b",
               tag, s, victim_way, set_full, ev, ef);
    end
  endtask

  // Drive one cycle, check the pre-edge outputs for the addressed set, then update the model.
  task automatic step(int s, bit av, bit ah, int hw, bit fl, string tag);
    @(negedge clk);
    set_idx = SIW'(s); acc_valid = av; acc_hit = ah; hit_way = AW'(hw); fill = fl;
    #1;
    check_outputs(s, tag);
    @(posedge clk);
    model_apply(s, av, ah, hw, fl);
  endtask

  task automatic look(int s, string tag);
    step(s, 1'b0, 1'b0, 0, 1'b0, tag);
  endtask

  initial begin
    #2_000_000;
    tests_failed++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    for (int s = 0; s < SETS; s++) begin
      cnt[s] = 0;
      for (int w = 0; w < WAYS; w++) begin vld[s][w] = 1'b0; ord[s][w] = 0; end
    end
    rst_n = 1'b0; set_idx = '0; acc_valid = 1'b0; acc_hit = 1'b0; hit_way = '0; fill = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: reset state on every set
    for (int s = 0; s < SETS; s++) look(s, "R1");

    // R5 / R2: filling set 0 picks ways 0,1,2,3 in order
    for (int i = 0; i < WAYS; i++) step(0, 1'b0, 1'b0, 0, 1'b1, "R5");
    // R8: now full; R3: way 0 is the oldest
    look(0, "R8");
    look(0, "R3");
    // R4: hit way 0 -> way 1 becomes oldest
    step(0, 1'b1, 1'b1, 0, 1'b0, "R4");
    look(0, "R4");
    // R4: hit way 2 (middle age) -> way 1 still oldest, order of others kept
    step(0, 1'b1, 1'b1, 2, 1'b0, "R4");
    look(0, "R4");
    // R6: fill into full set replaces way 1, next oldest is way 3
    step(0, 1'b0, 1'b0, 0, 1'b1, "R6");
    look(0, "R6");
    // R9: hit fields with access strobe low on the oldest way: no change
    step(0, 1'b0, 1'b1, 3, 1'b0, "R9");
    look(0, "R9");
    // R10: hit and fill together on a full set: only the hit counts
    step(0, 1'b1, 1'b1, 3, 1'b1, "R10");
    look(0, "R10");

    // R11: partly filled set 1, hit on an invalid way has no effect
    step(1, 1'b0, 1'b0, 0, 1'b1, "R5");
    step(1, 1'b0, 1'b0, 0, 1'b1, "R5");
    step(1, 1'b1, 1'b1, 3, 1'b0, "R11");
    look(1, "R11");
    // R10: hit and fill together on a set that is not full
    step(1, 1'b1, 1'b1, 0, 1'b1, "R10");
    look(1, "R10");
    step(1, 1'b0, 1'b0, 0, 1'b1, "R2");
    // R7: set 0 untouched by set 1 traffic
    look(0, "R7");
    look(2, "R7");

    // Random phase over a few sets so they fill and churn (R4, R6, R7, R10 mixed)
    for (int n = 0; n < 4000; n++) begin
      int  s;
      bit  av, ah, fl;
      int  hw;
      s  = $urandom_range(0, 3);
      av = ($urandom_range(0, 99) < 60);
      ah = ($urandom_range(0, 99) < 70);
      hw = $urandom_range(0, WAYS - 1);
      fl = ($urandom_range(0, 99) < 35);
      step(s, av, ah, hw, fl, "RND");
    end
    for (int s = 0; s < SETS; s++) look(s, "R7");

    $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end
endmodule